// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block fetches transmit work from a ring of descriptors in a shared word-addressed memory and turns it into a byte stream. A poll pulse starts a walk at the current ring position. Each descriptor is eight 32-bit words. The walk fetches the descriptor's control word, buffer size word and buffer address word through a request/acknowledge memory port. It streams the buffer's bytes out on a byte-wide valid/last interface. Then it hands the descriptor back to software by writing the control word with the ownership bit cleared.

The walk continues through consecutive descriptors that hardware owns and stops at the first one it does not own. A frame may span any number of descriptors, and the one holding the end-of-frame flag raises a completion event when its write-back finishes. A wrap flag returns the current position to the ring base, and the ring base is loaded, together with the current position, from a word-address input.

Top module: `txring_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `tx_valid`, `tx_last`, `frame_done`, `sum_evt` and `mem_req` are all low.
- R2: For a descriptor whose control word (word 0) has bit 31 set, the engine reads word 1 and word 2 and then emits the buffer's bytes in increasing address order. The byte count is bits 11:0 of word 1, so bits 15:12 have no effect. The buffer start address is word 2. While a request is pending, `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`.
- R3: A fetched control word with bit 31 clear ends the walk. Nothing is emitted, nothing is written, and the engine returns to idle.
- R4: After its buffer is sent, the descriptor's word 0 is written back to the same address with bit 31 cleared and all other bits unchanged.
- R5: `tx_last` is high only with `tx_valid`, and only on the final byte of a descriptor whose control bit 29 is set. A frame may span several descriptors.
- R6: The write-back acknowledge of a descriptor with bit 29 set is followed in the next cycle by a one-cycle pulse on both `frame_done` and `sum_evt`.
- R7: After write-back, the current position becomes the ring base if control bit 21 is set. Otherwise it advances by one descriptor (32 bytes).
- R8: A byte count of zero emits no bytes, but the descriptor is still written back, the position still advances, and bit 29 still raises the completion pulse.
- R9: A poll pulse that arrives during a walk is remembered. A further walk starts at the current position once the engine is idle.
- R10: A `base_load` pulse sets both the ring base and the current position to `ring_base`.
- R11: Buffers may start at any byte address. Memory words are little-endian, so the byte at address A is bits 8*(A mod 4)+7 : 8*(A mod 4) of word A/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | Poll-demand pulse |
| base_load | input | 1 | Load ring base and current position |
| ring_base | input | ADDR_W-2 | Ring base as a word address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| frame_done | output | 1 | Transmit-complete event pulse |
| sum_evt | output | 1 | Normal-summary event pulse |

## Verification
The bench builds frames that span several descriptors and start at unaligned buffer addresses. A design that misplaces the byte lane, or that asserts last on the end of every descriptor, shows up as byte or flag mismatches in the scoreboard. A zero-length descriptor sits in the middle of a walk, which catches a design that stalls on it, skips its write-back, or drops its completion pulse. A wrap descriptor is placed ahead of an owned descriptor that must not be reached, so a design that advances instead of wrapping emits unexpected bytes. A second poll issued mid-walk must cause a second read of the terminating descriptor, which a design that forgets the poll never performs.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CTL, S_SIZE, S_ADDR, S_BRD, S_EMIT, S_WB
  } walk_st_t;

  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 29;
  localparam int WRAP_BIT = 21;
endpackage

// File: rtl/txw_poll_latch.sv
module txw_poll_latch (
  input  logic clk,
  input  logic rst,
  input  logic poll,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~take) | poll;
  end
endmodule

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
  parameter int WA_W       = 14,
  parameter int DESC_WORDS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_load,
  input  logic [WA_W-1:0] base_in,
  input  logic            step,
  input  logic            wrap,
  output logic [WA_W-1:0] cur
);
  logic [WA_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur    <= '0;
    end else if (base_load) begin
      base_q <= base_in;
      cur    <= base_in;
    end else if (step) begin
      cur <= wrap ? base_q : cur + WA_W'(DESC_WORDS);
    end
  end
endmodule

// File: rtl/txw_byte_lane.sv
module txw_byte_lane #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [SEL_W-1:0]   sel,
  output logic [7:0]         byte_out
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end

  assign byte_out = lane[sel];
endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int DESC_BYTES = 32,
  localparam int WA_W       = ADDR_W - 2,
  localparam int DESC_WORDS = DESC_BYTES / 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            poll,
  input  logic            base_load,
  input  logic [WA_W-1:0] ring_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [WA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  output logic            frame_done,
  output logic            sum_evt
);
  import txw_pkg::*;

  walk_st_t          st;
  logic [31:0]       ctl;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] bp;
  logic [31:0]       word;
  logic [WA_W-1:0]   cur;
  logic              pend;
  logic              take;
  logic              step;
  logic [7:0]        lane_byte;
  logic              txv_q, txl_q, done_q;
  logic [7:0]        txd_q;

  assign take = (st == S_IDLE) && pend;
  assign step = (st == S_WB) && mem_ack;

  txw_poll_latch u_poll (
    .clk  (clk),
    .rst  (rst),
    .poll (poll),
    .take (take),
    .pend (pend)
  );

  txw_ring_ptr #(.WA_W(WA_W), .DESC_WORDS(DESC_WORDS)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .base_load (base_load),
    .base_in   (ring_base),
    .step      (step),
    .wrap      (ctl[WRAP_BIT]),
    .cur       (cur)
  );

  txw_byte_lane #(.LANES(4)) u_lane (
    .word     (word),
    .sel      (bp[1:0]),
    .byte_out (lane_byte)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = {1'b0, ctl[30:0]};
    unique case (st)
      S_CTL:  mem_req = 1'b1;
      S_SIZE: begin mem_req = 1'b1; mem_addr = cur + WA_W'(1); end
      S_ADDR: begin mem_req = 1'b1; mem_addr = cur + WA_W'(2); end
      S_BRD:  begin mem_req = 1'b1; mem_addr = bp[ADDR_W-1:2]; end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ctl    <= '0;
      rem    <= '0;
      bp     <= '0;
      word   <= '0;
      txv_q  <= 1'b0;
      txd_q  <= '0;
      txl_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      txv_q  <= 1'b0;
      txl_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (pend) st <= S_CTL;
        S_CTL: if (mem_ack) begin
          ctl <= mem_rdata;
          st  <= mem_rdata[OWN_BIT] ? S_SIZE : S_IDLE;
        end
        S_SIZE: if (mem_ack) begin
          rem <= mem_rdata[LEN_W-1:0];
          st  <= S_ADDR;
        end
        S_ADDR: if (mem_ack) begin
          bp <= mem_rdata[ADDR_W-1:0];
          st <= (rem == '0) ? S_WB : S_BRD;
        end
        S_BRD: if (mem_ack) begin
          word <= mem_rdata;
          st   <= S_EMIT;
        end
        S_EMIT: begin
          txv_q <= 1'b1;
          txd_q <= lane_byte;
          txl_q <= (rem == LEN_W'(1)) && ctl[LAST_BIT];
          bp    <= bp + ADDR_W'(1);
          rem   <= rem - LEN_W'(1);
          if (rem == LEN_W'(1))     st <= S_WB;
          else if (bp[1:0] == 2'b11) st <= S_BRD;
        end
        S_WB: if (mem_ack) begin
          done_q <= ctl[LAST_BIT];
          st     <= S_CTL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tx_valid   = txv_q;
  assign tx_data    = txd_q;
  assign tx_last    = txl_q;
  assign frame_done = done_q;
  assign sum_evt    = done_q;
endmodule

// File: rtl/txring_walker_chk.sv
module txring_walker_chk #(
  parameter int WA_W = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic            mem_we,
  input logic [WA_W-1:0] mem_addr,
  input logic [31:0]     mem_wdata,
  input logic            mem_ack,
  input logic            tx_valid,
  input logic            tx_last,
  input logic            frame_done
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && !frame_done && !mem_req));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r4_owner_cleared: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  a_r6_done_after_wb: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(mem_ack && mem_we));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

bind txring_walker txring_walker_chk #(.WA_W(WA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .tx_valid   (tx_valid),
  .tx_last    (tx_last),
  .frame_done (frame_done)
);

// File: tb/txring_walker_tb.sv
module txring_walker_tb;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] LST = 32'h2000_0000;
  localparam logic [31:0] WRP = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        poll = 1'b0;
  logic        base_load = 1'b0;
  logic [13:0] ring_base = '0;
  logic        mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        tx_valid, tx_last, frame_done, sum_evt;
  logic [7:0]  tx_data;

  logic [31:0] mem [0:1023];
  logic [8:0]  expq [$];
  int checks = 0, errors = 0;
  int done_cnt = 0, sum_cnt = 0, watch_rd = 0;
  logic [13:0] watch_w = '1;

  always #10 clk = ~clk;

  txring_walker u_dut (
    .clk(clk), .rst(rst), .poll(poll), .base_load(base_load), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .frame_done(frame_done), .sum_evt(sum_evt)
  );

  function automatic logic [7:0] fb(int x);
    return 8'((x * 7 + 3) ^ (x >> 8));
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:0]];
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected byte", {23'd0, tx_last, tx_data}, 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({tx_last, tx_data} == e, "R2/R5/R11 byte or last", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
      if (frame_done) done_cnt++;
      if (sum_evt) sum_cnt++;
      if (mem_ack && !mem_we && mem_addr == watch_w) watch_rd++;
    end
  end

  task automatic put_desc(input int a, input logic [31:0] c, input logic [31:0] sz, input logic [31:0] ba);
    @(negedge clk);
    mem[10'(a >> 2)]     <= c;
    mem[10'(a >> 2) + 1] <= sz;
    mem[10'(a >> 2) + 2] <= ba;
    mem[10'(a >> 2) + 3] <= '0;
  endtask

  task automatic expect_bytes(input int a, input int n, input bit last);
    for (int i = 0; i < n; i++)
      expq.push_back({(last && i == n - 1), fb(a + i)});
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 10) begin
      @(negedge clk);
      if (mem_req) q = 0; else q++;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 1024; w++)
      mem[w] <= (w < 128) ? 32'd0 : {fb(4*w+3), fb(4*w+2), fb(4*w+1), fb(4*w)};
    repeat (5) @(negedge clk);
    // R1 during reset
    check(!tx_valid && !tx_last && !frame_done && !sum_evt && !mem_req, "R1 reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_valid && !frame_done && !sum_evt && !mem_req, "R1 after reset", 0, 0);

    // R10 base at 0
    base_load = 1'b1; ring_base = '0;
    @(negedge clk); base_load = 1'b0;

    // T1: single descriptor, size high bits ignored (R2), write-back (R4), done (R6)
    put_desc(32'h000, OWN | LST | 32'h00AB, 32'h0000_F005, 32'h200);
    expect_bytes(32'h200, 5, 1'b1);
    do_poll(); wait_quiet();
    check(expq.size() == 0, "R2 all bytes sent", expq.size(), 0);
    check(done_cnt == 1, "R6 frame_done count", done_cnt, 1);
    check(sum_cnt == 1, "R6 sum_evt count", sum_cnt, 1);
    check(mem[0] == (LST | 32'h00AB), "R4 write-back word", mem[0], LST | 32'h00AB);

    // T2: frame over two descriptors, unaligned buffers (R5, R11, R7 advance)
    put_desc(32'h020, OWN, 32'd3, 32'h301);
    put_desc(32'h040, OWN | LST, 32'd6, 32'h402);
    expect_bytes(32'h301, 3, 1'b0);
    expect_bytes(32'h402, 6, 1'b1);
    do_poll(); wait_quiet();
    check(expq.size() == 0, "R5 multi-descriptor frame", expq.size(), 0);
    check(done_cnt == 2, "R6 one pulse per frame", done_cnt, 2);
    check(mem[8] == 32'd0, "R4 middle descriptor written back", mem[8], 0);
    check(mem[24] == 32'd0, "R3 unowned stop untouched", mem[24], 0);

    // T3: zero length with last (R8)
    put_desc(32'h060, OWN | LST, 32'h0000_F000, 32'h500);
    put_desc(32'h080, OWN | LST, 32'd2, 32'h510);
    expect_bytes(32'h510, 2, 1'b1);
    do_poll(); wait_quiet();
    check(expq.size() == 0, "R8 zero length then next", expq.size(), 0);
    check(done_cnt == 4, "R8 zero length completion", done_cnt, 4);
    check(mem[24] == LST, "R8 zero length write-back", mem[24], LST);

    // T4: unowned at current position stops walk (R3)
    put_desc(32'h0C0, OWN | LST, 32'd4, 32'h700);
    do_poll(); wait_quiet();
    check(done_cnt == 4, "R3 no completion", done_cnt, 4);
    check(mem[48] == (OWN | LST), "R3 later descriptor kept", mem[48], OWN | LST);

    // T5: wrap to base (R7)
    put_desc(32'h0A0, OWN | WRP | LST, 32'd1, 32'h600);
    expect_bytes(32'h600, 1, 1'b1);
    do_poll(); wait_quiet();
    check(expq.size() == 0, "R7 wrap descriptor sent", expq.size(), 0);
    put_desc(32'h000, OWN | LST, 32'd2, 32'h610);
    expect_bytes(32'h610, 2, 1'b1);
    do_poll(); wait_quiet();
    check(expq.size() == 0, "R7 walk resumed at base", expq.size(), 0);
    check(done_cnt == 6, "R7 completions", done_cnt, 6);

    // T6: new base (R10), single poll reads stop slot once
    base_load = 1'b1; ring_base = 14'(32'h180 >> 2);
    @(negedge clk); base_load = 1'b0;
    put_desc(32'h180, OWN | LST, 32'd3, 32'h620);
    expect_bytes(32'h620, 3, 1'b1);
    watch_w = 14'(32'h1A0 >> 2); watch_rd = 0;
    do_poll(); wait_quiet();
    check(expq.size() == 0, "R10 walk from loaded base", expq.size(), 0);
    check(watch_rd == 1, "R9 single poll one stop read", watch_rd, 1);

    // T7: poll during walk remembered (R9)
    put_desc(32'h1A0, OWN | LST, 32'd40, 32'h640);
    expect_bytes(32'h640, 40, 1'b1);
    watch_w = 14'(32'h1C0 >> 2); watch_rd = 0;
    do_poll();
    repeat (8) @(negedge clk);
    do_poll();
    wait_quiet();
    check(expq.size() == 0, "R9 long frame sent", expq.size(), 0);
    check(watch_rd == 2, "R9 pending poll rewalks", watch_rd, 2);
    check(done_cnt == 8, "R6 final completions", done_cnt, 8);

    finish_run();
  end
endmodule